// File: doc/BRIEF.md
# Reorder Buffer with Register Rename Map

This block keeps in-flight instructions in program order inside a small circular buffer and renames their destination registers so that execution can proceed in dataflow order. A decoded instruction is written at the tail slot, whose index becomes its tag. Each of its two sources is captured at that moment. If no older instruction in flight writes the register, the source takes the architectural value. If the producer has already finished, it takes the producer's result. Otherwise it keeps the producer's tag and waits for that result.

The lowest-indexed slot whose operands are both present and which has not started is offered to the execution side. Finished results return as tag/value broadcasts. A broadcast fills the producing slot and wakes every waiting source that holds that tag. The oldest slot retires into the architectural register file once its result is present. If that slot carries a nonzero fault code, the block reports an exception instead, drops every in-flight instruction and forgets all register mappings.

A read port on the architectural register file exposes the committed state.

Top module: `rob_rename_top`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, `iss_valid`, `cm_valid` and `exc_valid` are 0, and every architectural register reads 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both high at a clock edge) takes the slot named by `alloc_tag`. Tags advance by one per accepted allocation and wrap modulo 4. Without an allocation or exception, the tag holds.
- R3: A source register is captured at allocation as follows. With no in-flight writer, it takes the architectural value and is ready. If the newest writer has finished, it takes that writer's result. Otherwise it waits, and the instruction is not offered until that writer's result arrives.
- R4: The execution offer presents the lowest slot index whose operands are both ready and which has not started, together with its operation and both operand values. Once `iss_ack` is taken for that slot, the slot is not offered again.
- R5: A broadcast on `wb_valid`/`wb_tag`/`wb_data` wakes every waiting source holding that tag with `wb_data`. This includes a source being allocated in the same cycle.
- R6: Retirement is in program order. The oldest entry retires only when its result is present. `cm_valid`, `cm_dest` and `cm_data` show it, and the architectural register is written at that edge. A finished younger entry waits.
- R7: Retiring an entry drops the register mapping only when the map still names that entry's tag. A younger writer of the same register keeps its mapping, and later readers wait on it.
- R8: When the oldest finished entry has a nonzero `wb_cause` (0 means no fault), `exc_valid` is 1 with that cause and nothing is written. All entries are discarded and the allocation tag returns to the oldest entry's slot. All mappings are cleared, so later sources read architectural values.
- R9: With 4 entries in flight, `alloc_ready` is 0, and an allocation request leaves the tag and the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | 4 | Operation code stored with the entry |
| alloc_dest | input | 3 | Destination register |
| alloc_src1 | input | 3 | First source register |
| alloc_src2 | input | 3 | Second source register |
| alloc_ready | output | 1 | Allocation will be accepted this cycle |
| alloc_tag | output | 2 | Tag the next allocation receives |
| iss_valid | output | 1 | An entry is offered for execution |
| iss_tag | output | 2 | Tag of the offered entry |
| iss_op | output | 4 | Operation of the offered entry |
| iss_a | output | 16 | First operand value |
| iss_b | output | 16 | Second operand value |
| iss_ack | input | 1 | Offered entry starts execution |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | 2 | Tag of the producing entry |
| wb_data | input | 16 | Result value |
| wb_cause | input | 3 | Fault code, 0 for none |
| cm_valid | output | 1 | Oldest entry retires this cycle |
| cm_dest | output | 3 | Register being written |
| cm_data | output | 16 | Value being written |
| exc_valid | output | 1 | Oldest entry faults, buffer flushes this cycle |
| exc_cause | output | 3 | Fault code of that entry |
| rd_addr | input | 3 | Architectural register read address |
| rd_data | output | 16 | Architectural register value (combinational) |

## Verification
An allocation shows up on the execution offer in the cycle after its edge. A broadcast shows up on the woken operands, and on the retire or exception outputs of the oldest entry, in the cycle after its edge. The architectural register read port shows a retired value one further cycle later.

The bench drives all inputs just after a rising edge and samples outputs one nanosecond later, before the next edge. Each check is placed in the first cycle where its result is due by this count. A sweep over every pair of source registers covers capture from the register file, and hand-built sequences cover waiting, same-cycle wake-up, ordering, remapping, the full stall and the fault flush.

// File: rtl/rob_pkg.sv
package rob_pkg;
    parameter int NUM_AREGS = 8;
    parameter int ROB_SLOTS = 4;   // power of two
    parameter int XLEN      = 16;
    parameter int OP_W      = 4;
    parameter int CAUSE_W   = 3;

    localparam int AREG_W = $clog2(NUM_AREGS);
    localparam int SLOT_W = $clog2(ROB_SLOTS);
    localparam int PTR_W  = SLOT_W + 1;

    typedef logic [AREG_W-1:0]  areg_t;
    typedef logic [SLOT_W-1:0]  tag_t;
    typedef logic [PTR_W-1:0]   ptr_t;
    typedef logic [XLEN-1:0]    word_t;
    typedef logic [OP_W-1:0]    op_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    // One source operand: either a value (rdy=1) or a producer tag (rdy=0)
    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        word_t val;
    } opnd_t;

    typedef struct packed {
        logic   busy;
        logic   started;
        op_t    op;
        opnd_t  a;
        opnd_t  b;
        logic   done;
        areg_t  dest;
        word_t  data;
        cause_t cause;
    } slot_t;

    // Source capture at allocation time
    function automatic opnd_t capture_src(input logic  map_v,
                                          input tag_t  map_tag,
                                          input logic  prod_done,
                                          input word_t prod_data,
                                          input logic  bc_v,
                                          input tag_t  bc_tag,
                                          input word_t bc_data,
                                          input word_t arf_val);
        opnd_t o;
        o.rdy = 1'b1;
        o.tag = map_tag;
        o.val = arf_val;
        if (map_v) begin
            if (prod_done) begin
                o.val = prod_data;
            end else if (bc_v && bc_tag == map_tag) begin
                o.val = bc_data;
            end else begin
                o.rdy = 1'b0;
                o.val = '0;
            end
        end
        return o;
    endfunction

    function automatic logic ptr_full(input ptr_t h, input ptr_t t);
        return (h[SLOT_W] != t[SLOT_W]) && (h[SLOT_W-1:0] == t[SLOT_W-1:0]);
    endfunction
endpackage

// File: rtl/rob_rename_map.sv
module rob_rename_map
    import rob_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_all,
    input  areg_t rd_a,
    input  areg_t rd_b,
    output logic  hit_a,
    output logic  hit_b,
    output tag_t  tag_a,
    output tag_t  tag_b,
    input  logic  set_en,
    input  areg_t set_reg,
    input  tag_t  set_tag,
    input  logic  rel_en,
    input  areg_t rel_reg,
    input  tag_t  rel_tag
);
    logic vld_q [NUM_AREGS];
    tag_t map_q [NUM_AREGS];

    generate
        for (genvar r = 0; r < NUM_AREGS; r++) begin : g_map
            always_ff @(posedge clk) begin
                if (rst || clr_all) begin
                    vld_q[r] <= 1'b0;
                end else if (set_en && set_reg == areg_t'(r)) begin
                    vld_q[r] <= 1'b1;
                end else if (rel_en && rel_reg == areg_t'(r) && map_q[r] == rel_tag) begin
                    vld_q[r] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    map_q[r] <= '0;
                end else if (set_en && set_reg == areg_t'(r)) begin
                    map_q[r] <= set_tag;
                end
            end
        end
    endgenerate

    assign hit_a = vld_q[rd_a];
    assign hit_b = vld_q[rd_b];
    assign tag_a = map_q[rd_a];
    assign tag_b = map_q[rd_b];
endmodule

// File: rtl/rob_arch_regs.sv
module rob_arch_regs
    import rob_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  areg_t wa,
    input  word_t wd,
    input  areg_t ra0,
    input  areg_t ra1,
    input  areg_t ra2,
    output word_t rd0,
    output word_t rd1,
    output word_t rd2
);
    word_t regs_q [NUM_AREGS];

    generate
        for (genvar r = 0; r < NUM_AREGS; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_q[r] <= '0;
                end else if (we && wa == areg_t'(r)) begin
                    regs_q[r] <= wd;
                end
            end
        end
    endgenerate

    assign rd0 = regs_q[ra0];
    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];
endmodule

// File: rtl/rob_issue_pick.sv
module rob_issue_pick
    import rob_pkg::*;
(
    input  logic [ROB_SLOTS-1:0] elig,
    output logic                 found,
    output tag_t                 pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = ROB_SLOTS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                pick  = tag_t'(i);
            end
        end
    end
endmodule

// File: rtl/rob_rename_top.sv
module rob_rename_top
    import rob_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_valid,
    input  logic [OP_W-1:0]      alloc_op,
    input  logic [AREG_W-1:0]    alloc_dest,
    input  logic [AREG_W-1:0]    alloc_src1,
    input  logic [AREG_W-1:0]    alloc_src2,
    output logic                 alloc_ready,
    output logic [SLOT_W-1:0]    alloc_tag,
    output logic                 iss_valid,
    output logic [SLOT_W-1:0]    iss_tag,
    output logic [OP_W-1:0]      iss_op,
    output logic [XLEN-1:0]      iss_a,
    output logic [XLEN-1:0]      iss_b,
    input  logic                 iss_ack,
    input  logic                 wb_valid,
    input  logic [SLOT_W-1:0]    wb_tag,
    input  logic [XLEN-1:0]      wb_data,
    input  logic [CAUSE_W-1:0]   wb_cause,
    output logic                 cm_valid,
    output logic [AREG_W-1:0]    cm_dest,
    output logic [XLEN-1:0]      cm_data,
    output logic                 exc_valid,
    output logic [CAUSE_W-1:0]   exc_cause,
    input  logic [AREG_W-1:0]    rd_addr,
    output logic [XLEN-1:0]      rd_data
);
    slot_t rob_q [ROB_SLOTS];
    ptr_t  head_q, tail_q;
    tag_t  head_idx, tail_idx;
    logic  full, head_fin, commit_fire, flush, alloc_fire, iss_fire;

    logic  hit_a, hit_b;
    tag_t  mtag_a, mtag_b;
    word_t arf_a, arf_b;
    opnd_t new_a, new_b;
    logic [ROB_SLOTS-1:0] elig;

    assign head_idx    = head_q[SLOT_W-1:0];
    assign tail_idx    = tail_q[SLOT_W-1:0];
    assign full        = ptr_full(head_q, tail_q);
    assign head_fin    = rob_q[head_idx].busy && rob_q[head_idx].done;
    assign commit_fire = head_fin && (rob_q[head_idx].cause == '0);
    assign flush       = head_fin && (rob_q[head_idx].cause != '0);
    assign alloc_ready = !full && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_idx;

    rob_rename_map u_map (
        .clk     (clk),
        .rst     (rst),
        .clr_all (flush),
        .rd_a    (alloc_src1),
        .rd_b    (alloc_src2),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .tag_a   (mtag_a),
        .tag_b   (mtag_b),
        .set_en  (alloc_fire),
        .set_reg (alloc_dest),
        .set_tag (tail_idx),
        .rel_en  (commit_fire),
        .rel_reg (rob_q[head_idx].dest),
        .rel_tag (head_idx)
    );

    rob_arch_regs u_arf (
        .clk (clk),
        .rst (rst),
        .we  (commit_fire),
        .wa  (rob_q[head_idx].dest),
        .wd  (rob_q[head_idx].data),
        .ra0 (alloc_src1),
        .ra1 (alloc_src2),
        .ra2 (rd_addr),
        .rd0 (arf_a),
        .rd1 (arf_b),
        .rd2 (rd_data)
    );

    always_comb begin
        new_a = capture_src(hit_a, mtag_a, rob_q[mtag_a].done, rob_q[mtag_a].data,
                            wb_valid, wb_tag, wb_data, arf_a);
        new_b = capture_src(hit_b, mtag_b, rob_q[mtag_b].done, rob_q[mtag_b].data,
                            wb_valid, wb_tag, wb_data, arf_b);
    end

    // Slot storage, one register per entry
    generate
        for (genvar i = 0; i < ROB_SLOTS; i++) begin : g_slot
            slot_t s_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    s_q <= '0;
                end else if (flush) begin
                    s_q.busy <= 1'b0;
                end else if (alloc_fire && tail_idx == tag_t'(i)) begin
                    s_q <= '{busy: 1'b1, started: 1'b0, op: alloc_op, a: new_a, b: new_b,
                             done: 1'b0, dest: alloc_dest, data: '0, cause: '0};
                end else begin
                    if (commit_fire && head_idx == tag_t'(i)) begin
                        s_q.busy <= 1'b0;
                    end
                    if (iss_fire && iss_tag == tag_t'(i)) begin
                        s_q.started <= 1'b1;
                    end
                    if (wb_valid && s_q.busy && wb_tag == tag_t'(i)) begin
                        s_q.done  <= 1'b1;
                        s_q.data  <= wb_data;
                        s_q.cause <= wb_cause;
                    end
                    if (wb_valid && s_q.busy && !s_q.a.rdy && s_q.a.tag == wb_tag) begin
                        s_q.a.rdy <= 1'b1;
                        s_q.a.val <= wb_data;
                    end
                    if (wb_valid && s_q.busy && !s_q.b.rdy && s_q.b.tag == wb_tag) begin
                        s_q.b.rdy <= 1'b1;
                        s_q.b.val <= wb_data;
                    end
                end
            end

            assign rob_q[i] = s_q;
            assign elig[i]  = s_q.busy && !s_q.started && s_q.a.rdy && s_q.b.rdy;
        end
    endgenerate

    rob_issue_pick u_pick (
        .elig  (elig),
        .found (iss_valid),
        .pick  (iss_tag)
    );

    assign iss_fire = iss_valid && iss_ack;
    assign iss_op   = rob_q[iss_tag].op;
    assign iss_a    = rob_q[iss_tag].a.val;
    assign iss_b    = rob_q[iss_tag].b.val;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (flush) begin
            tail_q <= head_q;
        end else begin
            if (alloc_fire) begin
                tail_q <= tail_q + 1'b1;
            end
            if (commit_fire) begin
                head_q <= head_q + 1'b1;
            end
        end
    end

    assign cm_valid  = commit_fire;
    assign cm_dest   = rob_q[head_idx].dest;
    assign cm_data   = rob_q[head_idx].data;
    assign exc_valid = flush;
    assign exc_cause = rob_q[head_idx].cause;
endmodule

// File: rtl/rob_rename_sva.sv
module rob_rename_sva
    import rob_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        alloc_valid,
    input logic        alloc_ready,
    input tag_t        alloc_tag,
    input logic        iss_valid,
    input logic        iss_ack,
    input tag_t        iss_tag,
    input logic        cm_valid,
    input logic        exc_valid
);
    localparam ptr_t FULL_CNT = ptr_t'(ROB_SLOTS);

    ptr_t occ_q;
    logic take;

    assign take = alloc_valid && alloc_ready;

    always_ff @(posedge clk) begin
        if (rst || exc_valid) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + ptr_t'(take) - ptr_t'(cm_valid);
        end
    end

    assert_full_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (occ_q == FULL_CNT) |-> !alloc_ready);

    assert_room_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (occ_q < FULL_CNT && !exc_valid) |-> alloc_ready);

    assert_tag_step_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> alloc_tag == tag_t'($past(alloc_tag) + 1'b1));

    assert_tag_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!take && !exc_valid) |=> $stable(alloc_tag));

    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> (!iss_valid && !cm_valid && alloc_ready));

    assert_issue_once_R4: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ack) |=> !(iss_valid && iss_tag == $past(iss_tag)));

    assert_empty_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (occ_q == '0) |-> (!iss_valid && !cm_valid && !exc_valid));
endmodule

bind rob_rename_top rob_rename_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .alloc_tag   (alloc_tag),
    .iss_valid   (iss_valid),
    .iss_ack     (iss_ack),
    .iss_tag     (iss_tag),
    .cm_valid    (cm_valid),
    .exc_valid   (exc_valid)
);

// File: tb/tb_rob_rename_top.sv
`timescale 1ns/1ps
module tb_rob_rename_top;
    import rob_pkg::*;

    logic   clk = 1'b0;
    logic   rst;
    logic   alloc_valid;
    op_t    alloc_op;
    areg_t  alloc_dest, alloc_src1, alloc_src2;
    logic   alloc_ready;
    tag_t   alloc_tag;
    logic   iss_valid;
    tag_t   iss_tag;
    op_t    iss_op;
    word_t  iss_a, iss_b;
    logic   iss_ack;
    logic   wb_valid;
    tag_t   wb_tag;
    word_t  wb_data;
    cause_t wb_cause;
    logic   cm_valid;
    areg_t  cm_dest;
    word_t  cm_data;
    logic   exc_valid;
    cause_t exc_cause;
    areg_t  rd_addr;
    word_t  rd_data;

    int n_chk = 0;
    int n_fail = 0;
    word_t arf_m [NUM_AREGS];
    int tail_m = 0;
    int head_m = 0;

    always #2 clk = ~clk;

    rob_rename_top dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_dest(alloc_dest),
        .alloc_src1(alloc_src1), .alloc_src2(alloc_src2),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op),
        .iss_a(iss_a), .iss_b(iss_b), .iss_ack(iss_ack),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_cause(wb_cause),
        .cm_valid(cm_valid), .cm_dest(cm_dest), .cm_data(cm_data),
        .exc_valid(exc_valid), .exc_cause(exc_cause),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Start a new cycle: step past the edge and drop single-cycle inputs
    task automatic nxt();
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
        iss_ack     = 1'b0;
        wb_valid    = 1'b0;
    endtask

    task automatic put(input int d, input int s1, input int s2);
        alloc_valid = 1'b1;
        alloc_op    = op_t'(d + s1 + s2);
        alloc_dest  = areg_t'(d);
        alloc_src1  = areg_t'(s1);
        alloc_src2  = areg_t'(s2);
    endtask

    task automatic bc(input int t, input word_t v, input int c);
        wb_valid = 1'b1;
        wb_tag   = tag_t'(t);
        wb_data  = v;
        wb_cause = cause_t'(c);
    endtask

    function automatic int wrap(input int x);
        return x % ROB_SLOTS;
    endfunction

    // One instruction end to end; sources read architectural values
    task automatic single(input int d, input int s1, input int s2, input word_t v);
        int t;
        nxt();
        put(d, s1, s2);
        #1;
        check("R2 tag", alloc_tag, wrap(tail_m));
        t = wrap(tail_m);
        nxt();
        tail_m++;
        #1;
        check("R4 offer", {iss_valid, iss_tag}, {1'b1, tag_t'(t)});
        check("R4 op", iss_op, op_t'(d + s1 + s2));
        check("R3 src1", iss_a, arf_m[s1]);
        check("R3 src2", iss_b, arf_m[s2]);
        iss_ack = 1'b1;
        nxt();
        #1;
        check("R4 once", iss_valid, 1'b0);
        bc(t, v, 0);
        nxt();
        #1;
        check("R6 retire", {cm_valid, cm_dest, cm_data}, {1'b1, areg_t'(d), v});
        nxt();
        head_m++;
        arf_m[d] = v;
        rd_addr = areg_t'(d);
        #1;
        check("R6 arf", rd_data, v);
        check("R6 idle", cm_valid, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int tA, tB, tC, tD, tE, tF, tG, tH, lo, hi;
        rst = 1'b1;
        alloc_valid = 0; alloc_op = '0; alloc_dest = '0; alloc_src1 = '0; alloc_src2 = '0;
        iss_ack = 0; wb_valid = 0; wb_tag = '0; wb_data = '0; wb_cause = '0; rd_addr = '0;
        for (int r = 0; r < NUM_AREGS; r++) arf_m[r] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 ready", alloc_ready, 1'b1);
        check("R1 tag", alloc_tag, 0);
        check("R1 outputs", {iss_valid, cm_valid, exc_valid}, 3'b000);
        for (int r = 0; r < NUM_AREGS; r++) begin
            rd_addr = areg_t'(r);
            #0.1;
            check("R1 arf", rd_data, 0);
        end

        // Sweep every source pair (R2, R3, R4, R6)
        for (int s1 = 0; s1 < NUM_AREGS; s1++) begin
            for (int s2 = 0; s2 < NUM_AREGS; s2++) begin
                single((s1 + s2) % NUM_AREGS, s1, s2, word_t'((s1 * 8 + s2) * 97 + 3));
            end
        end

        // Dependencies, wake-up and order
        nxt(); put(2, 1, 1); #1;
        check("R2 tag A", alloc_tag, wrap(tail_m)); tA = wrap(tail_m);
        nxt(); tail_m++; put(3, 2, 4); #1;
        check("R2 tag B", alloc_tag, wrap(tail_m)); tB = wrap(tail_m);
        check("R4 offer A", {iss_valid, iss_tag}, {1'b1, tag_t'(tA)});
        iss_ack = 1'b1;
        nxt(); tail_m++; #1;
        check("R3 B waits", iss_valid, 1'b0);
        bc(tA, 16'h1234, 0);
        nxt(); #1;
        check("R6 retire A", {cm_valid, cm_dest, cm_data}, {1'b1, areg_t'(2), 16'h1234});
        check("R5 wake B", {iss_valid, iss_tag, iss_a}, {1'b1, tag_t'(tB), 16'h1234});
        check("R3 B src2", iss_b, arf_m[4]);
        iss_ack = 1'b1;
        put(6, 2, 3); tC = wrap(tail_m);
        nxt(); tail_m++; head_m++; arf_m[2] = 16'h1234; #1;
        check("R3 C waits", iss_valid, 1'b0);
        bc(tB, 16'h0BEE, 0);
        put(7, 3, 0); tD = wrap(tail_m);
        nxt(); tail_m++; #1;
        check("R6 retire B", {cm_valid, cm_dest, cm_data}, {1'b1, areg_t'(3), 16'h0BEE});
        lo = (tC < tD) ? tC : tD;
        hi = (tC < tD) ? tD : tC;
        check("R4 lowest", {iss_valid, iss_tag}, {1'b1, tag_t'(lo)});
        check("R5 bypass or wake", iss_a, (lo == tC) ? 16'h1234 : 16'h0BEE);
        iss_ack = 1'b1;
        nxt(); head_m++; arf_m[3] = 16'h0BEE; #1;
        check("R4 next", {iss_valid, iss_tag}, {1'b1, tag_t'(hi)});
        check("R5 operand b", iss_b, (hi == tC) ? 16'h0BEE : arf_m[0]);
        iss_ack = 1'b1;
        nxt(); #1;
        check("R4 drained", iss_valid, 1'b0);
        bc(tD, 16'h7777, 0);
        nxt(); #1;
        check("R6 younger waits", cm_valid, 1'b0);
        bc(tC, 16'h5555, 0);
        nxt(); #1;
        check("R6 retire C", {cm_valid, cm_dest, cm_data}, {1'b1, areg_t'(6), 16'h5555});
        nxt(); head_m++; arf_m[6] = 16'h5555; #1;
        check("R6 retire D", {cm_valid, cm_dest, cm_data}, {1'b1, areg_t'(7), 16'h7777});
        nxt(); head_m++; arf_m[7] = 16'h7777; rd_addr = 3'd7; #1;
        check("R6 arf D", rd_data, 16'h7777);

        // Same register written twice (R7)
        nxt(); put(1, 0, 0); tE = wrap(tail_m); #1;
        nxt(); tail_m++; put(1, 0, 0); tF = wrap(tail_m); #1;
        check("R7 offer E", {iss_valid, iss_tag}, {1'b1, tag_t'(tE)});
        iss_ack = 1'b1;
        nxt(); tail_m++; #1;
        check("R7 offer F", {iss_valid, iss_tag}, {1'b1, tag_t'(tF)});
        iss_ack = 1'b1;
        bc(tE, 16'h0A0A, 0);
        nxt(); #1;
        check("R7 retire E", {cm_valid, cm_dest, cm_data}, {1'b1, areg_t'(1), 16'h0A0A});
        nxt(); head_m++; arf_m[1] = 16'h0A0A; put(5, 1, 0); tG = wrap(tail_m); #1;
        nxt(); tail_m++; #1;
        check("R7 G waits on F", iss_valid, 1'b0);
        bc(tF, 16'h0F0F, 0);
        nxt(); #1;
        check("R7 retire F", {cm_valid, cm_dest, cm_data}, {1'b1, areg_t'(1), 16'h0F0F});
        check("R7 G woken", {iss_valid, iss_tag, iss_a}, {1'b1, tag_t'(tG), 16'h0F0F});
        iss_ack = 1'b1;
        nxt(); head_m++; arf_m[1] = 16'h0F0F; #1;
        bc(tG, 16'h0C0C, 0);
        nxt(); #1;
        check("R7 retire G", {cm_valid, cm_dest, cm_data}, {1'b1, areg_t'(5), 16'h0C0C});
        nxt(); head_m++; arf_m[5] = 16'h0C0C; rd_addr = 3'd1; #1;
        check("R7 arf youngest", rd_data, 16'h0F0F);

        // Fill (R9), then fault flush (R8)
        for (int k = 0; k < ROB_SLOTS; k++) begin
            nxt(); put(4, 1, 2); #1;
            check("R9 room", {alloc_ready, alloc_tag}, {1'b1, tag_t'(wrap(tail_m))});
            nxt(); tail_m++;
        end
        #1;
        put(0, 0, 0);
        #1;
        check("R9 full stall", alloc_ready, 1'b0);
        nxt(); #1;
        check("R9 tag kept", alloc_tag, wrap(tail_m));
        bc(wrap(head_m), 16'hDEAD, 3);
        nxt(); #1;
        check("R8 exception", {exc_valid, exc_cause, cm_valid}, {1'b1, 3'd3, 1'b0});
        nxt(); tail_m = head_m; #1;
        check("R8 emptied", {exc_valid, alloc_ready, iss_valid}, 3'b010);
        check("R8 tag rewound", alloc_tag, wrap(head_m));
        put(6, 4, 4); tH = wrap(tail_m);
        nxt(); tail_m++; rd_addr = 3'd4; #1;
        check("R8 map cleared", {iss_valid, iss_tag, iss_a}, {1'b1, tag_t'(tH), arf_m[4]});
        check("R8 no write", rd_data, arf_m[4]);
        iss_ack = 1'b1;
        nxt(); #1;
        bc(tH, 16'h1111, 0);
        nxt(); #1;
        check("R8 resumes", {cm_valid, cm_dest, cm_data}, {1'b1, areg_t'(6), 16'h1111});
        nxt();

        summary();
        $finish;
    end
endmodule